// File: doc/BRIEF.md
# Resolution-Configurable Conversion Sequencer

This block paces the periodic temperature conversions of a digital thermometer and turns each raw reading into a 16-bit result word. The analog front end is not part of it. A raw 12-bit two's complement sample arrives on a data port together with a one-cycle valid strobe, and the block keeps the most recent one. A two-bit resolution code and a shutdown bit come from the configuration register. When a conversion window ends, the block copies the held sample into the result register and clears the low bits that the selected resolution does not cover. It then raises a one-cycle done pulse for the downstream thermostat logic.

The window length depends on the resolution. Its cycle count for 9-bit resolution is a parameter, and each added bit doubles it. A new resolution code is latched only when a window starts, so a window never changes its length or its mask part way through. If shutdown is requested, the window that is running still completes and stores its result, and the block then idles. Clearing shutdown starts a fresh window on the next clock.

Top module: `tsq_conv_sequencer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `result` is 0, `conv_done` is 0 and `conv_busy` is 1. The first window uses 9-bit resolution whatever `cfg_res` holds.
- R2: A window at resolution code c (00, 01, 10, 11 selecting 9, 10, 11, 12 bits) lasts BASE_CYCLES << c clock cycles. With continuous conversion, `conv_done` pulses exactly that many cycles apart. The first pulse comes that many cycles after the last clock edge at which `rst` is high.
- R3: The result word is the held sample in bits 15..4, with bits 3..0 always zero. At code c, bits (6-c)..0 are also zero, so only the top 9+c bits carry data. Negative values therefore round toward minus infinity.
- R4: `conv_done` is high for exactly one cycle, and only in the cycle after `result` is written. `result` does not change in any cycle where `conv_done` is low.
- R5: A change of `cfg_res` during a window does not affect that window's length or masking. It applies from the next window that starts.
- R6: If `cfg_shutdown` is high when a window completes, that window still stores its result and pulses `conv_done`, and in the same cycle `conv_busy` drops to 0. After that there are no further `conv_done` pulses and `result` holds while shutdown stays high.
- R7: When `cfg_shutdown` is low in the idle state, `conv_busy` rises one cycle later and continuous conversion resumes. The new window uses the resolution present on `cfg_res` at that edge.
- R8: Every cycle with `smp_valid` high replaces the held sample, including cycles while idle. Data presented with `smp_valid` low is ignored. A result uses the last sample held before the edge that completes its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_res | input | 2 | Resolution code: 00=9, 01=10, 10=11, 11=12 bits |
| cfg_shutdown | input | 1 | 1 requests standby after the current window |
| smp_valid | input | 1 | Strobe qualifying `smp_data` |
| smp_data | input | 12 | Raw two's complement sample, 1/16 degree per LSB |
| result | output | 16 | Formatted temperature word |
| conv_done | output | 1 | One-cycle pulse when `result` is updated |
| conv_busy | output | 1 | 1 while a conversion window is running |

## Verification
The embedded properties assume that BASE_CYCLES is at least 2, so that two completions can never fall on adjacent cycles. They also assume that the configuration inputs are synchronous levels, sampled only at the edge where a window completes or starts. The stimulus changes `cfg_res`, `cfg_shutdown` and the sample only on the falling edge just after a done pulse, well away from the next completion edge, so each window has a single unambiguous resolution and sample. Sample strobes last one cycle. One window carries data with the strobe low, and one strobe arrives while the block is idle.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  // Narrowest supported resolution in bits; code 0 selects it.
  localparam int TSQ_MIN_BITS = 9;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } tsq_state_e;

  // Bits that must read zero for a given resolution code.
  function automatic logic [31:0] tsq_zero_field(input int out_w, input int min_bits, input int code);
    return (32'd1 << (out_w - min_bits - code)) - 32'd1;
  endfunction

endpackage

// File: rtl/tsq_sample_hold.sv
module tsq_sample_hold #(
  parameter int RAW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [RAW_W-1:0] data,
  output logic [RAW_W-1:0] held
);

  always_ff @(posedge clk) begin
    if (rst)        held <= '0;
    else if (valid) held <= data;
  end

  // R8: without a strobe the held sample must not move
  a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(held));

  // R8: a strobe always lands its data
  a_r8_capture_on_strobe: assert property (@(posedge clk) disable iff (rst)
    valid |=> held == $past(data));

endmodule

// File: rtl/tsq_interval_timer.sv
module tsq_interval_timer #(
  parameter int BASE_CYCLES = 16,
  parameter int CODE_W      = 2,
  parameter int CNT_W       = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              run,
  output logic              expired
);

  localparam int NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] reload_tab [NCODES];
  logic [CNT_W-1:0] cnt;

  // Each code doubles the window of the previous one.
  for (genvar gi = 0; gi < NCODES; gi++) begin : g_reload
    assign reload_tab[gi] = CNT_W'((BASE_CYCLES << gi) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= reload_tab[0];
    else if (load)               cnt <= reload_tab[code];
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

  // R2: the countdown never leaves the longest window
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= reload_tab[NCODES-1]);

  // R2: while running and not reloaded, the count only falls
  a_r2_count_falls: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/tsq_result_format.sv
module tsq_result_format #(
  parameter int RAW_W    = 12,
  parameter int OUT_W    = 16,
  parameter int MIN_BITS = 9,
  parameter int CODE_W   = 2
) (
  input  logic [RAW_W-1:0]  raw,
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  word
);

  localparam int NCODES = 1 << CODE_W;
  localparam int PAD_W  = OUT_W - RAW_W;

  logic [OUT_W-1:0] keep [NCODES];

  // Keep mask per resolution; the pad below the raw field is always cleared.
  for (genvar gi = 0; gi < NCODES; gi++) begin : g_keep
    localparam int ZB   = OUT_W - MIN_BITS - gi;
    localparam int ZB_C = (ZB < PAD_W) ? PAD_W : ZB;
    assign keep[gi] = {OUT_W{1'b1}} << ZB_C;
  end

  assign word = {raw, {PAD_W{1'b0}}} & keep[code];

endmodule

// File: rtl/tsq_conv_sequencer.sv
module tsq_conv_sequencer
  import tsq_pkg::*;
#(
  parameter int BASE_CYCLES = 16,
  parameter int CODE_W      = 2,
  parameter int RAW_W       = 12,
  parameter int OUT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cfg_res,
  input  logic              cfg_shutdown,
  input  logic              smp_valid,
  input  logic [RAW_W-1:0]  smp_data,
  output logic [OUT_W-1:0]  result,
  output logic              conv_done,
  output logic              conv_busy
);

  localparam int NCODES = 1 << CODE_W;
  localparam int CNT_W  = $clog2(BASE_CYCLES << (NCODES - 1));
  localparam int PAD_W  = OUT_W - RAW_W;

  tsq_state_e        state;
  logic [CODE_W-1:0] res_lat;
  logic [RAW_W-1:0]  held;
  logic [OUT_W-1:0]  fmt_word;
  logic              expired;
  logic              finish;
  logic              start_conv;

  tsq_sample_hold #(.RAW_W(RAW_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .valid (smp_valid),
    .data  (smp_data),
    .held  (held)
  );

  tsq_interval_timer #(
    .BASE_CYCLES (BASE_CYCLES),
    .CODE_W      (CODE_W),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (start_conv),
    .code    (cfg_res),
    .run     (state == ST_CONV),
    .expired (expired)
  );

  tsq_result_format #(
    .RAW_W    (RAW_W),
    .OUT_W    (OUT_W),
    .MIN_BITS (TSQ_MIN_BITS),
    .CODE_W   (CODE_W)
  ) u_fmt (
    .raw  (held),
    .code (res_lat),
    .word (fmt_word)
  );

  assign finish     = (state == ST_CONV) && expired;
  assign start_conv = !cfg_shutdown && (finish || state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CONV;
      res_lat   <= '0;
      result    <= '0;
      conv_done <= 1'b0;
    end else begin
      conv_done <= finish;
      if (finish)     result  <= fmt_word;
      if (start_conv) res_lat <= cfg_res;
      case (state)
        ST_CONV: if (finish && cfg_shutdown) state <= ST_IDLE;
        ST_IDLE: if (!cfg_shutdown)          state <= ST_CONV;
        default:                             state <= ST_IDLE;
      endcase
    end
  end

  assign conv_busy = (state == ST_CONV);

  // Independent window-age counter used only by the checks below.
  logic [CNT_W-1:0] chk_age;
  always_ff @(posedge clk) begin
    if (rst)                   chk_age <= '0;
    else if (start_conv)       chk_age <= '0;
    else if (state == ST_CONV) chk_age <= chk_age + 1'b1;
  end

  // R2 / R5: a window closes after exactly the length of its latched code
  a_r2_conv_length: assert property (@(posedge clk) disable iff (rst)
    finish |-> (int'(chk_age) + 1 == (BASE_CYCLES << res_lat)));

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !conv_done);

  // R4: the result only moves alongside a done pulse
  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    !conv_done |-> $stable(result));

  // R3: the pad nibble is never set
  a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
    result[PAD_W-1:0] == '0);

  // R3: bits below the finished window's resolution read zero
  a_r3_mask_width: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> (result & OUT_W'(tsq_zero_field(OUT_W, TSQ_MIN_BITS, int'($past(res_lat))))) == '0);

  // R6: the block only goes idle as a window completes
  a_r6_idle_entry: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_busy) |-> conv_done);

  // R6: no completions while idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!conv_busy && $past(!conv_busy)) |-> !conv_done);

  // R7: idle with shutdown released resumes on the next edge
  a_r7_resume: assert property (@(posedge clk) disable iff (rst)
    (!conv_busy && !cfg_shutdown) |=> conv_busy);

endmodule

// File: tb/tsq_conv_sequencer_tb.sv
`timescale 1ns/1ps
module tsq_conv_sequencer_tb;

  localparam int BASE = 16;

  typedef struct {
    logic [15:0] val;
    int          len;
  } exp_t;

  logic        clk;
  logic        rst;
  logic [1:0]  cfg_res;
  logic        cfg_shutdown;
  logic        smp_valid;
  logic [11:0] smp_data;
  logic [15:0] result;
  logic        conv_done;
  logic        conv_busy;

  exp_t        q[$];
  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;
  int          mark   = 0;
  bit          prev_busy = 1'b1;
  int          cur_res = 0;
  logic [11:0] raw_m = '0;
  bit          finished = 1'b0;

  tsq_conv_sequencer #(.BASE_CYCLES(BASE)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .cfg_res      (cfg_res),
    .cfg_shutdown (cfg_shutdown),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .result       (result),
    .conv_done    (conv_done),
    .conv_busy    (conv_busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] fmt(input logic [11:0] s, input int r);
    logic [15:0] w;
    w = {s, 4'h0};
    return w & ~((16'd1 << (7 - r)) - 16'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Monitor / scoreboard: sample 2 ns after each rising edge.
  always @(posedge clk) begin
    cyc++;
    #2;
    if (rst) begin
      mark      = cyc;
      prev_busy = 1'b1;
    end else begin
      if (conv_busy && !prev_busy) mark = cyc;
      if (conv_done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6", "done pulse with nothing expected", 32'(result), 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(result == e.val, "R3/R8", "result word", 32'(result), 32'(e.val));
          chk(cyc - mark == e.len, "R2/R5", "window length", 32'(cyc - mark), 32'(e.len));
        end
        mark = cyc;
      end
      prev_busy = conv_busy;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!conv_done);
  endtask

  // Driver: called on the falling edge right after a done pulse (or reset).
  task automatic step(input logic [1:0] nres, input logic [11:0] s, input bit v);
    if (v) raw_m = s;
    q.push_back('{val: fmt(raw_m, cur_res), len: BASE << cur_res});
    cfg_res   = nres;
    smp_data  = s;
    smp_valid = v;
    @(negedge clk);
    smp_valid = 1'b0;
    wait_done();
    cur_res = int'(nres);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 32'(cyc), 32'h0);
    report();
  end

  initial begin
    rst          = 1'b1;
    cfg_res      = 2'b11;
    cfg_shutdown = 1'b0;
    smp_valid    = 1'b0;
    smp_data     = '0;
    repeat (3) @(negedge clk);
    chk(result == 16'h0,  "R1", "reset result", 32'(result), 32'h0);
    chk(conv_done == 1'b0, "R1", "reset done",  32'(conv_done), 32'h0);
    chk(conv_busy == 1'b1, "R1", "reset busy",  32'(conv_busy), 32'h1);
    rst = 1'b0;

    // R1: first window is 9-bit although cfg_res was 11 in reset
    step(2'b01, 12'h7D0, 1'b1);   // expect 7D00, 16 cycles
    // R5: resolution code changes while windows run
    step(2'b11, 12'hFFF, 1'b1);   // 10-bit: FFC0, 32 cycles
    step(2'b10, 12'h191, 1'b1);   // 12-bit: 1910, 128 cycles
    // R8: data without strobe is ignored
    step(2'b00, 12'hF5E, 1'b0);   // 11-bit on held 191: 1900, 64 cycles
    step(2'b00, 12'hFFF, 1'b1);   // 9-bit: FF80, 16 cycles

    // R6: shutdown requested mid-window; window still completes
    q.push_back('{val: fmt(12'hC90, cur_res), len: BASE << cur_res});
    raw_m        = 12'hC90;
    cfg_shutdown = 1'b1;
    cfg_res      = 2'b11;
    smp_data     = 12'hC90;
    smp_valid    = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    wait_done();
    chk(conv_busy == 1'b0, "R6", "busy after shutdown completion", 32'(conv_busy), 32'h0);
    // R8: strobe while idle is captured for the next window
    @(negedge clk);
    smp_data  = 12'h0A2;
    smp_valid = 1'b1;
    raw_m     = 12'h0A2;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (384) @(negedge clk);
    chk(result == 16'hC900, "R6", "result held in standby", 32'(result), 32'hC900);
    chk(conv_busy == 1'b0,  "R6", "still idle", 32'(conv_busy), 32'h0);

    // R7: release shutdown; resumes with the code present at restart
    cfg_res = 2'b10;
    cur_res = 2;
    q.push_back('{val: fmt(raw_m, cur_res), len: BASE << cur_res}); // 0A20, 64
    cfg_shutdown = 1'b0;
    @(negedge clk);
    chk(conv_busy == 1'b1, "R7", "busy after release", 32'(conv_busy), 32'h1);
    wait_done();
    cfg_res = 2'b10;
    // R7: continuous conversion again
    step(2'b00, 12'h001, 1'b1);   // 11-bit: 0000, 64 cycles
    step(2'b00, 12'h7D0, 1'b1);   // 9-bit: 7D00, 16 cycles

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R4", "all expected results seen", 32'(q.size()), 32'h0);
    report();
  end

endmodule